// File: doc/BRIEF.md
# Trigger-Gated Burst Capture Framer

This block sits between a free-running ADC sample stream and a write-side FIFO that feeds a host. While a trigger level is high, each valid sample becomes a 64-bit data word with the sample in the low half and zeros in the high half. When the trigger falls, the block writes one terminator word. The terminator's high half holds the number of samples taken during that pulse, and its low half is zero. A reader that has lost words can therefore scan for the next word with a nonzero high half and realign to burst boundaries. No flush and no side handshake are needed.

The FIFO's full indication never stalls capture. Data words offered while the FIFO is full are dropped, but they are still counted, and they set a sticky overflow flag. A terminator is never lost: if it cannot be written, it waits and goes out before anything else. A test mode replaces ADC samples with an incrementing pattern, so the host can detect gaps.

The controller has three states:
- `ST_IDLE` waits for a trigger rising edge.
- `ST_CAPTURE` forwards samples while the trigger stays high.
- `ST_TERM_WAIT` holds a terminator that met a full FIFO.

Transitions:
- `ST_IDLE`→`ST_CAPTURE` on a rising edge.
- `ST_CAPTURE`→`ST_IDLE` on a falling edge with room in the FIFO (terminator written).
- `ST_CAPTURE`→`ST_TERM_WAIT` on a falling edge with the FIFO full.
- `ST_TERM_WAIT`→`ST_IDLE` when the terminator is written and the trigger is low.
- `ST_TERM_WAIT`→`ST_CAPTURE` when the terminator is written and the trigger is high.

Top module: `burst_framer`

## Requirements
- R1: Samples are written only while a burst is open. A burst opens in the cycle where `trig_i` is high after a low cycle (or after reset), and stays open while `trig_i` is high. In `ST_IDLE` with no rising edge, no word is written.
- R2: At burst start the sample count restarts. The count then increases by one for each cycle with `sample_vld_i` high inside the burst, including samples that are dropped.
- R3: A data word is `wr_data_o = {32'h0, sample}`, with `wr_en_o` high in the cycle after the sample was presented.
- R4: In the first cycle with `trig_i` low after a burst, exactly one terminator `{count, 32'h0}` is requested. If the FIFO is not full, it appears on the outputs one cycle later. A data word and a terminator are never written in the same cycle.
- R5: A sample presented while `fifo_full_i` is high produces no write, and capture continues.
- R6: `ovf_o` goes high after any dropped data word and stays high until `ovf_clr_i` is pulsed. A drop in the same cycle as a clear wins.
- R7: A terminator that meets a full FIFO is held in `ST_TERM_WAIT`. It is written in the first cycle the FIFO is not full, before any new data.
- R8: A trigger that rises while a terminator is pending starts a new burst only once the terminator is written. If `trig_i` is high in that cycle, capture resumes from the next cycle with the count reset to zero. The sample in the terminator's cycle is not taken.
- R9: The terminator count is at least 1, so a burst with no valid samples reports 1.
- R10: With `test_mode_i` high, each taken sample is replaced by an internal counter that starts at 0 after reset. The counter steps once per taken sample, dropped or not.
- R11: `burst_cnt_o` increments by one, modulo 2^BCNT_W, for each terminator written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger level gating capture |
| sample_i | input | DATA_W | ADC sample |
| sample_vld_i | input | 1 | Sample valid strobe |
| fifo_full_i | input | 1 | Downstream FIFO full |
| test_mode_i | input | 1 | Select counting test pattern |
| ovf_clr_i | input | 1 | Clear sticky overflow flag |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 2*DATA_W | Data or terminator word |
| ovf_o | output | 1 | Sticky overflow flag |
| burst_cnt_o | output | BCNT_W | Count of terminators written |

## Verification
The bench builds the framer with DATA_W = 32 and BCNT_W = 2. With a 2-bit burst counter, five bursts in the vector table are enough to wrap it, which checks the modulo behaviour of R11. The table exercises dropped data, a terminator held across a full FIFO while the trigger rises again, and an empty pulse that forces the minimum count. The test-pattern run drops a sample in mid-burst, so the gap shows in the data words.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_TERM_WAIT
    } bcf_state_e;
endpackage

// File: rtl/bcf_source.sv
module bcf_source #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] value_o
);
    logic [DATA_W-1:0] pattern_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pattern_q <= '0;
        else if (take_i && test_mode_i)
            pattern_q <= pattern_q + 1'b1;
    end

    assign value_o = test_mode_i ? pattern_q : sample_i;

    AST_PATTERN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && test_mode_i) |=> (pattern_q == $past(pattern_q) + 1'b1)); // R10
endmodule

// File: rtl/bcf_ctrl.sv
module bcf_ctrl
    import bcf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              vld_i,
    input  logic              full_i,
    output logic              take_o,
    output logic              data_wr_o,
    output logic              term_wr_o,
    output logic              drop_o,
    output logic [DATA_W-1:0] count_o
);
    bcf_state_e        state_q, state_d;
    logic              trig_q;
    logic              rise;
    logic              start;
    logic [DATA_W-1:0] cnt_q;

    assign rise = trig_i && !trig_q;

    always_comb begin
        state_d   = state_q;
        start     = 1'b0;
        take_o    = 1'b0;
        term_wr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin
                    start   = 1'b1;
                    take_o  = vld_i;
                    state_d = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (trig_i) begin
                    take_o = vld_i;
                end else if (!full_i) begin
                    term_wr_o = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    state_d = ST_TERM_WAIT;
                end
            end
            ST_TERM_WAIT: begin
                if (!full_i) begin
                    term_wr_o = 1'b1;
                    start     = trig_i;
                    state_d   = trig_i ? ST_CAPTURE : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign data_wr_o = take_o && !full_i;
    assign drop_o    = take_o && full_i;
    assign count_o   = (cnt_q == '0) ? DATA_W'(1) : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            trig_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig_i;
            if (start)
                cnt_q <= DATA_W'(take_o);
            else if (take_o)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !trig_i) |-> !(data_wr_o || term_wr_o)); // R1
    AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |-> !(data_wr_o || term_wr_o)); // R5
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TERM_WAIT && full_i) |=> (state_q == ST_TERM_WAIT)); // R7
    AST_PEND_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TERM_WAIT) |-> !take_o); // R8
    AST_COUNT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        term_wr_o |-> (count_o != '0)); // R9
endmodule

// File: rtl/bcf_outreg.sv
module bcf_outreg #(
    parameter int DATA_W = 32,
    parameter int BCNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_wr_i,
    input  logic                term_wr_i,
    input  logic                drop_i,
    input  logic                ovf_clr_i,
    input  logic [DATA_W-1:0]   sample_i,
    input  logic [DATA_W-1:0]   count_i,
    output logic                wr_en_o,
    output logic [2*DATA_W-1:0] wr_data_o,
    output logic                ovf_o,
    output logic [BCNT_W-1:0]   burst_cnt_o
);
    localparam int WORD_W = 2 * DATA_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o     <= 1'b0;
            wr_data_o   <= '0;
            ovf_o       <= 1'b0;
            burst_cnt_o <= '0;
        end else begin
            wr_en_o <= data_wr_i || term_wr_i;
            if (term_wr_i)
                wr_data_o <= {count_i, {DATA_W{1'b0}}};
            else if (data_wr_i)
                wr_data_o <= {{DATA_W{1'b0}}, sample_i};
            else
                wr_data_o <= {WORD_W{1'b0}};
            if (drop_i)
                ovf_o <= 1'b1;
            else if (ovf_clr_i)
                ovf_o <= 1'b0;
            if (term_wr_i)
                burst_cnt_o <= burst_cnt_o + 1'b1;
        end
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr_i && term_wr_i)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o); // R6
    AST_BCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(burst_cnt_o) |-> (burst_cnt_o == $past(burst_cnt_o) + 1'b1)); // R11
    AST_WORD_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_data_o[WORD_W-1:DATA_W] != '0) |-> (wr_data_o[DATA_W-1:0] == '0)); // R3
endmodule

// File: rtl/burst_framer.sv
module burst_framer #(
    parameter int DATA_W = 32,
    parameter int BCNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_i,
    input  logic [DATA_W-1:0]   sample_i,
    input  logic                sample_vld_i,
    input  logic                fifo_full_i,
    input  logic                test_mode_i,
    input  logic                ovf_clr_i,
    output logic                wr_en_o,
    output logic [2*DATA_W-1:0] wr_data_o,
    output logic                ovf_o,
    output logic [BCNT_W-1:0]   burst_cnt_o
);
    logic              take;
    logic              data_wr;
    logic              term_wr;
    logic              drop;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] value;

    bcf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .vld_i     (sample_vld_i),
        .full_i    (fifo_full_i),
        .take_o    (take),
        .data_wr_o (data_wr),
        .term_wr_o (term_wr),
        .drop_o    (drop),
        .count_o   (count)
    );

    bcf_source #(.DATA_W(DATA_W)) u_source (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_mode_i (test_mode_i),
        .sample_i    (sample_i),
        .take_i      (take),
        .value_o     (value)
    );

    bcf_outreg #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_wr_i   (data_wr),
        .term_wr_i   (term_wr),
        .drop_i      (drop),
        .ovf_clr_i   (ovf_clr_i),
        .sample_i    (value),
        .count_i     (count),
        .wr_en_o     (wr_en_o),
        .wr_data_o   (wr_data_o),
        .ovf_o       (ovf_o),
        .burst_cnt_o (burst_cnt_o)
    );
endmodule

// File: tb/burst_framer_test.sv
module burst_framer_test;
    localparam int DATA_W = 32;
    localparam int BCNT_W = 2;
    localparam int VW     = 3 + DATA_W + 1 + 2 * DATA_W;
    localparam int NVEC   = 21;

    // {trig, vld, full, sample, exp_we, exp_data}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {3'b010, 32'h0000_00AA, 1'b0, 64'h0},                       // R1 idle, no trigger
        {3'b110, 32'h0000_0A01, 1'b1, 64'h0000_0000_0000_0A01},     // R2 R3 rise captures
        {3'b100, 32'h0,         1'b0, 64'h0},                       // R3 no valid
        {3'b110, 32'h0000_0A02, 1'b1, 64'h0000_0000_0000_0A02},     // R3
        {3'b111, 32'h0000_0A03, 1'b0, 64'h0},                       // R5 dropped
        {3'b110, 32'h0000_0A04, 1'b1, 64'h0000_0000_0000_0A04},     // R5 capture continues
        {3'b010, 32'h0000_0BAD, 1'b1, 64'h0000_0004_0000_0000},     // R2 R4 count includes drop
        {3'b010, 32'h0000_0BAD, 1'b0, 64'h0},                       // R1 idle ignores valid
        {3'b110, 32'h0000_0B01, 1'b1, 64'h0000_0000_0000_0B01},     // R1 new burst
        {3'b001, 32'h0,         1'b0, 64'h0},                       // R7 terminator held
        {3'b111, 32'h0000_0B02, 1'b0, 64'h0},                       // R8 rise while pending
        {3'b110, 32'h0000_0B03, 1'b1, 64'h0000_0001_0000_0000},     // R7 R8 terminator first
        {3'b110, 32'h0000_0B04, 1'b1, 64'h0000_0000_0000_0B04},     // R8 new burst data
        {3'b000, 32'h0,         1'b1, 64'h0000_0001_0000_0000},     // R8 count reset
        {3'b000, 32'h0,         1'b0, 64'h0},                       // R1
        {3'b100, 32'h0,         1'b0, 64'h0},                       // R9 empty pulse
        {3'b000, 32'h0,         1'b1, 64'h0000_0001_0000_0000},     // R9 forced min
        {3'b000, 32'h0,         1'b0, 64'h0},                       // R1
        {3'b110, 32'h0000_0C01, 1'b1, 64'h0000_0000_0000_0C01},     // R1
        {3'b010, 32'h0,         1'b1, 64'h0000_0001_0000_0000},     // R4
        {3'b000, 32'h0,         1'b0, 64'h0}                        // R1
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                trig_i = 1'b0;
    logic [DATA_W-1:0]   sample_i = '0;
    logic                sample_vld_i = 1'b0;
    logic                fifo_full_i = 1'b0;
    logic                test_mode_i = 1'b0;
    logic                ovf_clr_i = 1'b0;
    logic                wr_en_o;
    logic [2*DATA_W-1:0] wr_data_o;
    logic                ovf_o;
    logic [BCNT_W-1:0]   burst_cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    burst_framer #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .sample_i     (sample_i),
        .sample_vld_i (sample_vld_i),
        .fifo_full_i  (fifo_full_i),
        .test_mode_i  (test_mode_i),
        .ovf_clr_i    (ovf_clr_i),
        .wr_en_o      (wr_en_o),
        .wr_data_o    (wr_data_o),
        .ovf_o        (ovf_o),
        .burst_cnt_o  (burst_cnt_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic v, input logic f, input logic [DATA_W-1:0] s);
        trig_i = t;
        sample_vld_i = v;
        fifo_full_i = f;
        sample_i = s;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // reset state
        chk("R1 reset wr_en", 64'(wr_en_o), 64'h0);
        chk("R6 reset ovf", 64'(ovf_o), 64'h0);
        chk("R11 reset burst_cnt", 64'(burst_cnt_o), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3], VEC[i][VW-4 -: DATA_W]);
            chk($sformatf("R1-vec%0d wr_en", i), 64'(wr_en_o), 64'(VEC[i][2*DATA_W]));
            chk($sformatf("R3-vec%0d data", i), wr_data_o, VEC[i][2*DATA_W-1:0]);
        end

        // R11: five terminators with a 2-bit counter wrap to 1
        chk("R11 burst count wrap", 64'(burst_cnt_o), 64'd1);
        // R6: sticky after the drop, then cleared
        chk("R6 ovf sticky", 64'(ovf_o), 64'h1);
        ovf_clr_i = 1'b1;
        step(1'b0, 1'b0, 1'b0, '0);
        ovf_clr_i = 1'b0;
        chk("R6 ovf cleared", 64'(ovf_o), 64'h0);

        // R10: test pattern with a drop in mid-burst
        test_mode_i = 1'b1;
        step(1'b1, 1'b1, 1'b0, 32'hDEAD_0001);
        chk("R10 pattern first", wr_data_o, 64'h0);
        chk("R10 pattern first we", 64'(wr_en_o), 64'h1);
        step(1'b1, 1'b1, 1'b1, 32'hDEAD_0002);
        chk("R10 drop no write", 64'(wr_en_o), 64'h0);
        step(1'b1, 1'b1, 1'b0, 32'hDEAD_0003);
        chk("R10 pattern gap", wr_data_o, 64'h0000_0000_0000_0002);
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R4 test terminator", wr_data_o, 64'h0000_0003_0000_0000);
        chk("R6 ovf set again", 64'(ovf_o), 64'h1);
        chk("R11 burst count", 64'(burst_cnt_o), 64'd2);
        test_mode_i = 1'b0;

        // R6: drop wins over a simultaneous clear
        ovf_clr_i = 1'b1;
        step(1'b1, 1'b1, 1'b1, 32'h1);
        ovf_clr_i = 1'b0;
        chk("R6 drop beats clear", 64'(ovf_o), 64'h1);
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R9 terminator after drop only", wr_data_o, 64'h0000_0001_0000_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule